// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block collects a parameterised number of external interrupt lines for a single processor context and raises one interrupt request toward that processor. Each line has a programmable priority, an enable bit and a trigger-type bit choosing edge or level capture. A line that has been captured as pending, is enabled, is not already in service and carries a priority strictly above the programmable threshold is eligible. The request output is high whenever any line is eligible.

Software works through a 32-bit register port. A read of the claim/complete register returns the identifier of the winning line and moves it into service. A later write of the same identifier back to that register ends the service. Identifier 0 is reserved: it means "nothing pending" and is never a real source. Level lines that are still asserted when their service ends become pending again. Edge lines capture each rising edge, including an edge that arrives while the line is in service; such an edge is held and reported after completion.

Top module: `plic_core`

## Requirements
- R1: After reset, irq_o is low, and every priority, enable word, trigger word and the threshold read 0. A claim read returns 0.
- R2: The priority of source id is at byte address 4*id. A written value above MAX_PRIO (default 7) is stored as MAX_PRIO. Smaller values are stored as written. Read data appears on rdata_o in the cycle after the request.
- R3: Enable bits live at 0x2000 and trigger-type bits at 0x1080. Source id uses word id>>5, bit id&31, and a trigger bit of 1 selects edge capture. Source 0 has no priority, enable or trigger storage, and its fields always read 0.
- R4: irq_o is high only while some source is pending, enabled, not in service and has priority strictly above the threshold. A priority equal to the threshold, or a cleared enable bit, keeps a pending source from raising irq_o.
- R5: A read of the claim register at 0x200004 returns the eligible source with the highest priority. Among equal priorities the lowest id wins.
- R6: A claim read clears the winner's pending state and puts it in service, so irq_o falls when no other source is eligible. A claim read with nothing eligible returns 0 and changes nothing.
- R7: Writing a source id to 0x200004 ends that source's service. A level source whose input is still high is pending again one cycle after the completion, and one whose input is low is not.
- R8: An edge source captures only a 0-to-1 input change; an input that stays high does not capture again. An edge arriving while the source is in service, including in the very cycle it is claimed, is held and makes the source eligible once service ends.
- R9: A completion write naming 0, an id of NUM_SRC or more, or a source not in service has no effect.
- R10: The threshold at 0x200000 is clamped to MAX_PRIO on write in the same way as a priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Interrupt source lines, bit 0 unused |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 22 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hard coincidence is a claim read of an edge source landing on the same clock edge as a new rising edge on that source's input. The capture must survive the clearing that the claim performs. The bench provokes this by raising the line and issuing the claim read in the same cycle. It then expects irq_o to stay low while the source is in service, to rise right after the completion write, and a second claim to return the same id. A second overlap, a completion meeting a level input that is still high, is judged by the re-pend one cycle later.

// File: rtl/plic_pkg.sv
package plic_pkg;
  localparam int ADDR_W = 22;
  localparam logic [ADDR_W-1:0] PRIO_BASE  = 22'h000000;
  localparam logic [ADDR_W-1:0] TRIG_BASE  = 22'h001080;
  localparam logic [ADDR_W-1:0] EN_BASE    = 22'h002000;
  localparam logic [ADDR_W-1:0] THR_ADDR   = 22'h200000;
  localparam logic [ADDR_W-1:0] CLAIM_ADDR = 22'h200004;
endpackage

// File: rtl/plic_gateway.sv
module plic_gateway (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic edge_mode_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pend_o,
  output logic busy_o
);
  logic prev_q, pend_q, busy_q;
  logic rise;

  assign rise = src_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      prev_q <= src_i;
      if (edge_mode_i) begin
        // a fresh edge wins over the claim clearing it
        if (rise)         pend_q <= 1'b1;
        else if (claim_i) pend_q <= 1'b0;
      end else begin
        if (claim_i)                pend_q <= 1'b0;
        else if (src_i && !busy_q)  pend_q <= 1'b1;
      end
      if (claim_i)         busy_q <= 1'b1;
      else if (complete_i) busy_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             elig_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic                           valid_o,
  output logic [ID_W-1:0]                id_o
);
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    best_p  = '0;
    // strict compare keeps the lowest id on a tie
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig_i[i] && (!valid_o || prio_i[i] > best_p)) begin
        valid_o = 1'b1;
        best_p  = prio_i[i];
        id_o    = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/plic_regs.sv
module plic_regs
  import plic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int PRIO_W   = 3,
  parameter int MAX_PRIO = 7,
  localparam int ID_W     = $clog2(NUM_SRC),
  localparam int EN_WORDS = (NUM_SRC + 31) / 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [31:0]                    wdata_i,
  output logic [31:0]                    rdata_o,
  input  logic                           win_valid_i,
  input  logic [ID_W-1:0]                win_id_i,
  output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o,
  output logic [NUM_SRC-1:0]             en_o,
  output logic [NUM_SRC-1:0]             trig_o,
  output logic [PRIO_W-1:0]              thr_o,
  output logic                           claim_o,
  output logic                           cmp_valid_o,
  output logic [ID_W-1:0]                cmp_id_o
);
  localparam logic [ADDR_W-1:0] PRIO_END = PRIO_BASE + ADDR_W'(4 * NUM_SRC);
  localparam logic [ADDR_W-1:0] EN_END   = EN_BASE + ADDR_W'(4 * EN_WORDS);
  localparam logic [ADDR_W-1:0] TRIG_END = TRIG_BASE + ADDR_W'(4 * EN_WORDS);

  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_SRC-1:0]             en_q, trig_q;
  logic [PRIO_W-1:0]              thr_q;
  logic [31:0]                    rdata_q, rd_mux;
  logic                           wr, rd, aligned;
  logic                           prio_hit, en_hit, trig_hit, thr_hit, claim_hit;
  logic [ID_W-1:0]                pidx;
  logic [ADDR_W-1:0]              en_off, trig_off;
  logic [PRIO_W-1:0]              wclamp;

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign aligned = (addr_i[1:0] == 2'b00);
  assign en_off   = addr_i - EN_BASE;
  assign trig_off = addr_i - TRIG_BASE;

  assign prio_hit  = aligned && addr_i >= PRIO_BASE && addr_i < PRIO_END;
  assign en_hit    = aligned && addr_i >= EN_BASE && addr_i < EN_END;
  assign trig_hit  = aligned && addr_i >= TRIG_BASE && addr_i < TRIG_END;
  assign thr_hit   = (addr_i == THR_ADDR);
  assign claim_hit = (addr_i == CLAIM_ADDR);
  assign pidx      = addr_i[ID_W+1:2];

  assign wclamp = (wdata_i > 32'(MAX_PRIO)) ? PRIO_W'(MAX_PRIO) : wdata_i[PRIO_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      en_q   <= '0;
      trig_q <= '0;
      thr_q  <= '0;
    end else if (wr) begin
      for (int i = 1; i < NUM_SRC; i++) begin
        if (prio_hit && pidx == ID_W'(i)) prio_q[i] <= wclamp;
        if (en_hit && (i >> 5) == int'(en_off[ADDR_W-1:2]))
          en_q[i] <= wdata_i[i % 32];
        if (trig_hit && (i >> 5) == int'(trig_off[ADDR_W-1:2]))
          trig_q[i] <= wdata_i[i % 32];
      end
      if (thr_hit) thr_q <= wclamp;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (prio_hit) begin
      rd_mux = 32'(prio_q[pidx]);
    end else if (en_hit || trig_hit) begin
      for (int b = 0; b < 32; b++) begin
        for (int i = 0; i < NUM_SRC; i++) begin
          if (en_hit && i == int'(en_off[ADDR_W-1:2]) * 32 + b)
            rd_mux[b] = en_q[i];
          if (trig_hit && i == int'(trig_off[ADDR_W-1:2]) * 32 + b)
            rd_mux[b] = trig_q[i];
        end
      end
    end else if (thr_hit) begin
      rd_mux = 32'(thr_q);
    end else if (claim_hit) begin
      rd_mux = win_valid_i ? 32'(win_id_i) : 32'd0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign claim_o     = rd & claim_hit & win_valid_i;
  assign cmp_valid_o = wr & claim_hit & (wdata_i != 32'd0) & (wdata_i < 32'(NUM_SRC));
  assign cmp_id_o    = wdata_i[ID_W-1:0];

  assign rdata_o = rdata_q;
  assign prio_o  = prio_q;
  assign en_o    = en_q;
  assign trig_o  = trig_q;
  assign thr_o   = thr_q;
endmodule

// File: rtl/plic_core.sv
module plic_core
  import plic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int PRIO_W   = 3,
  parameter int MAX_PRIO = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [21:0]        addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               irq_o
);
  localparam int ID_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_w;
  logic [NUM_SRC-1:0]             en_w, trig_w, pend_w, busy_w, elig_w;
  logic [PRIO_W-1:0]              thr_w;
  logic                           claim_w, cmp_valid_w, win_valid_w;
  logic [ID_W-1:0]                cmp_id_w, win_id_w;

  plic_regs #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .MAX_PRIO(MAX_PRIO)
  ) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .win_valid_i(win_valid_w),
    .win_id_i   (win_id_w),
    .prio_o     (prio_w),
    .en_o       (en_w),
    .trig_o     (trig_w),
    .thr_o      (thr_w),
    .claim_o    (claim_w),
    .cmp_valid_o(cmp_valid_w),
    .cmp_id_o   (cmp_id_w)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    plic_gateway i_gw (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_i      (src_i[g]),
      .edge_mode_i(trig_w[g]),
      .claim_i    (claim_w && win_id_w == ID_W'(g)),
      .complete_i (cmp_valid_w && cmp_id_w == ID_W'(g)),
      .pend_o     (pend_w[g]),
      .busy_o     (busy_w[g])
    );
    assign elig_w[g] = pend_w[g] & ~busy_w[g] & en_w[g] & (prio_w[g] > thr_w);
  end

  plic_arbiter #(
    .NUM_SRC(NUM_SRC),
    .PRIO_W (PRIO_W)
  ) i_arb (
    .elig_i (elig_w),
    .prio_i (prio_w),
    .valid_o(win_valid_w),
    .id_o   (win_id_w)
  );

  assign irq_o = win_valid_w;
endmodule

// File: rtl/plic_checker.sv
module plic_checker
  import plic_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int MAX_PRIO = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [21:0]        addr_i,
  input logic [31:0]        rdata_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] pend_i,
  input logic [NUM_SRC-1:0] busy_i,
  input logic [NUM_SRC-1:0] en_i
);
  logic claim_rd, prio_rd;
  assign claim_rd = req_i && !we_i && addr_i == CLAIM_ADDR;
  assign prio_rd  = req_i && !we_i && addr_i[1:0] == 2'b00 && addr_i < 22'(4 * NUM_SRC);

  p_claim_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_rd && !irq_o |=> rdata_o == 32'd0);

  p_claim_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_rd && irq_o |=> rdata_o != 32'd0 && rdata_o < 32'(NUM_SRC));

  p_claim_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_rd && irq_o |=> $countones(busy_i) == $past($countones(busy_i)) + 1);

  p_prio_clamp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prio_rd |=> rdata_o <= 32'(MAX_PRIO));

  p_irq_source_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_i & ~busy_i & en_i) != '0);
endmodule

bind plic_core plic_checker #(
  .NUM_SRC (NUM_SRC),
  .MAX_PRIO(MAX_PRIO)
) i_plic_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .pend_i (pend_w),
  .busy_i (busy_w),
  .en_i   (en_w)
);

// File: tb/test_plic_core.sv
module test_plic_core;
  localparam int N = 32;
  localparam logic [21:0] A_TRIG  = 22'h001080;
  localparam logic [21:0] A_EN    = 22'h002000;
  localparam logic [21:0] A_THR   = 22'h200000;
  localparam logic [21:0] A_CLAIM = 22'h200004;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [21:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #4 clk = ~clk;

  plic_core #(.NUM_SRC(N)) i_plic_core (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: compare read data one cycle after each read request
  always @(posedge clk) rd_seen <= req & ~we;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        failures++;
        $display("FAIL %s rdata actual=%0h expected=%0h", t, rdata, e);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [21:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [21:0] a, input logic [31:0] e, input string t);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  task automatic set_src(input int id, input logic v);
    src[id] = v;
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk_irq(1'b0, "R1");
    bus_rd(22'(4 * 5), 32'd0, "R1 prio");
    bus_rd(A_EN, 32'd0, "R1 enable");
    bus_rd(A_TRIG, 32'd0, "R1 trig");
    bus_rd(A_THR, 32'd0, "R1 threshold");
    bus_rd(A_CLAIM, 32'd0, "R1 claim");
    // R2 priority clamp
    bus_wr(22'(4 * 3), 32'd9);
    bus_rd(22'(4 * 3), 32'd7, "R2 clamp");
    bus_wr(22'(4 * 4), 32'd2);
    bus_rd(22'(4 * 4), 32'd2, "R2 plain");
    bus_wr(22'(4 * 5), 32'd1);
    bus_wr(22'(4 * 6), 32'd3);
    bus_wr(22'(0), 32'd5);
    bus_rd(22'(0), 32'd0, "R3 id0 prio");
    // R10 threshold clamp
    bus_wr(A_THR, 32'd100);
    bus_rd(A_THR, 32'd7, "R10 clamp");
    bus_wr(A_THR, 32'd1);
    bus_rd(A_THR, 32'd1, "R10 plain");
    // R3 enable and trigger words
    bus_wr(A_EN, 32'hFFFF_FFFF);
    bus_rd(A_EN, 32'hFFFF_FFFE, "R3 enable id0");
    bus_wr(A_EN, 32'h78);
    bus_rd(A_EN, 32'h78, "R3 enable");
    bus_wr(A_TRIG, 32'h40);
    bus_rd(A_TRIG, 32'h40, "R3 trig");
    // R4 eligibility
    set_src(5, 1'b1);
    chk_irq(1'b0, "R4 prio equals threshold");
    set_src(4, 1'b1);
    chk_irq(1'b1, "R4 eligible");
    bus_wr(A_EN, 32'h68);
    chk_irq(1'b0, "R4 disabled");
    bus_wr(A_EN, 32'h78);
    chk_irq(1'b1, "R4 re-enabled");
    // R5/R6 claim
    bus_rd(A_CLAIM, 32'd4, "R5 claim");
    chk_irq(1'b0, "R6 irq after claim");
    bus_rd(A_CLAIM, 32'd0, "R6 empty claim");
    // R9 ignored completions
    bus_wr(A_CLAIM, 32'd5);
    bus_wr(A_CLAIM, 32'd0);
    bus_wr(A_CLAIM, 32'd36);
    tick();
    chk_irq(1'b0, "R9 ignored completion");
    // R7 level re-pend
    bus_wr(A_CLAIM, 32'd4);
    tick();
    chk_irq(1'b1, "R7 level re-pend");
    bus_rd(A_CLAIM, 32'd4, "R7 reclaim");
    set_src(4, 1'b0);
    bus_wr(A_CLAIM, 32'd4);
    tick();
    chk_irq(1'b0, "R7 no re-pend when low");
    // R5 tie and priority order
    bus_wr(22'(4 * 5), 32'd2);
    chk_irq(1'b1, "R4 raised prio");
    set_src(4, 1'b1);
    bus_rd(A_CLAIM, 32'd4, "R5 tie lowest id");
    src[4] = 1'b0;
    bus_wr(A_CLAIM, 32'd4);
    bus_rd(A_CLAIM, 32'd5, "R5 next");
    set_src(5, 1'b0);
    bus_wr(A_CLAIM, 32'd5);
    tick();
    chk_irq(1'b0, "R6 idle");
    src[3] = 1'b1; src[4] = 1'b1;
    tick();
    bus_rd(A_CLAIM, 32'd3, "R5 highest prio");
    src[3] = 1'b0; src[4] = 1'b0;
    tick();
    bus_wr(A_CLAIM, 32'd3);
    bus_rd(A_CLAIM, 32'd4, "R5 lower prio");
    bus_wr(A_CLAIM, 32'd4);
    tick();
    chk_irq(1'b0, "R6 idle 2");
    // R8 edge capture
    set_src(6, 1'b1);
    chk_irq(1'b1, "R8 edge");
    bus_rd(A_CLAIM, 32'd6, "R8 edge claim");
    tick(); tick();
    bus_wr(A_CLAIM, 32'd6);
    tick(); tick();
    chk_irq(1'b0, "R8 held high no retrigger");
    set_src(6, 1'b0);
    set_src(6, 1'b1);
    bus_rd(A_CLAIM, 32'd6, "R8 claim 2");
    set_src(6, 1'b0);
    set_src(6, 1'b1);
    chk_irq(1'b0, "R8 in service");
    bus_wr(A_CLAIM, 32'd6);
    chk_irq(1'b1, "R8 latched edge");
    bus_rd(A_CLAIM, 32'd6, "R8 latched claim");
    bus_wr(A_CLAIM, 32'd6);
    chk_irq(1'b0, "R8 drained");
    // R8 edge on the claim cycle
    set_src(6, 1'b0);
    set_src(6, 1'b1);
    chk_irq(1'b1, "R8 pending");
    set_src(6, 1'b0);
    src[6] = 1'b1;
    bus_rd(A_CLAIM, 32'd6, "R8 coincident claim");
    chk_irq(1'b0, "R8 coincident busy");
    bus_wr(A_CLAIM, 32'd6);
    chk_irq(1'b1, "R8 coincident edge kept");
    bus_rd(A_CLAIM, 32'd6, "R8 coincident reclaim");
    src[6] = 1'b0;
    bus_wr(A_CLAIM, 32'd6);
    tick();
    chk_irq(1'b0, "R8 final idle");
    tick(); tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule